// File: doc/BRIEF.md
# LPC Memory Cycle Target

This block is the peripheral side of a four-bit multiplexed LPC-style bus. It watches the frame strobe and the nibble lane from the host, recognises single-byte memory read and memory write cycles, collects the 32-bit address and the write data, and turns each cycle into one access on a plain internal memory port (address, write data, write strobe, read strobe, read data). On its own turns it drives the Ready sync code, the read-data nibbles and a turnaround value back toward the host through a drive-enable, then lets the lane go.

The bus is split at the block edge into an input nibble, an output nibble and an output enable, so a pad ring or a test bench forms the shared wire. Any clock with the frame strobe low forces the machine back into start detection. Cycle types other than memory are followed silently to the next frame. Only the Ready sync code is ever emitted, so the host never sees wait states.

The timing below counts clocks from the start clock, index 0. The start clock is the last clock with the frame strobe low, and the nibble on that clock is 0000.

Top module: `lpc_mem_target`

## Requirements
- R1: A cycle starts only on a clock where `frameN` is 0 and `ladIn` is 0000. A low `frameN` with any other nibble, or 0000 with `frameN` high, starts nothing.
- R2: At index 1 the type nibble is decoded: bits 3:2 = 01 marks a memory cycle, bit 1 = 1 means write and 0 means read, and bit 0 has no effect.
- R3: Indices 2 to 9 carry the address with bits 31:28 first and bits 3:0 last. `memAddr` shows the full address while either strobe is high and holds its value between address phases.
- R4: For a write, index 10 carries data bits 3:0 and index 11 carries bits 7:4. `memWe` is high for exactly one clock, at index 12, with the assembled byte on `memWdata`.
- R5: For a read, `memRe` is high for exactly one clock, at index 11. The byte that the memory presents on `memRdata` in the following clock is driven at index 13 (bits 3:0) and at index 14 (bits 7:4).
- R6: The target drives the Ready code 0000 for exactly one clock: at index 14 for a write and at index 12 for a read. No other sync code is ever driven.
- R7: After its last driven nibble the target drives 1111 for one clock (index 15), then releases the lane at index 16. `ladOe` is high only during the sync, data and 1111 clocks.
- R8: `frameN` low in any state ends the cycle. Strobes not yet issued are never issued, the drive stops one clock later, and a 0000 nibble on that same clock starts a new cycle.
- R9: A type nibble that is not a memory cycle causes no drive and no strobe until `frameN` next goes low.
- R10: While `rstN` is low, `ladOe`, `memWe` and `memRe` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameN | input | 1 | Active-low frame strobe from the host |
| ladIn | input | 4 | Nibble lane as seen from the bus |
| ladOut | output | 4 | Nibble the target drives |
| ladOe | output | 1 | Drive enable for `ladOut` |
| memAddr | output | 32 | Captured memory address |
| memWdata | output | 8 | Captured write byte |
| memWe | output | 1 | One-clock memory write strobe |
| memRe | output | 1 | One-clock memory read strobe |
| memRdata | input | 8 | Read byte, valid the clock after `memRe` |

## Verification
Writes and reads are each run with two type nibbles that differ only in bit 0. They use address patterns whose nibbles are all distinct, so a reversed or shifted address order shows up, and data bytes whose two halves differ, so swapped nibbles are caught. Non-memory types, a low frame with a non-start nibble, and 0000 sent with the frame high show that nothing else starts or answers a cycle. Aborts are placed just before the write strobe, just before the read strobe, in the middle of the driven read data, and inside the address with an immediate restart. Together they separate strobe suppression, drive release and same-clock restart from one another. A back-to-back read with no idle clock checks the return path from the final turnaround.

// File: rtl/lpc_tgt_pkg.sv
package lpc_tgt_pkg;

  localparam int LAD_W     = 4;
  localparam int DATA_NIBS = 2;
  localparam int DATA_W    = LAD_W * DATA_NIBS;

  localparam logic [LAD_W-1:0] NIB_START = 4'b0000;
  localparam logic [LAD_W-1:0] NIB_READY = 4'b0000;
  localparam logic [LAD_W-1:0] NIB_ONES  = 4'b1111;
  localparam logic [1:0]       MEM_KIND  = 2'b01;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_TYPE,
    ST_ADDR,
    ST_WDAT0,
    ST_WDAT1,
    ST_HTAR0,
    ST_HTAR1,
    ST_SYNC,
    ST_RDAT0,
    ST_RDAT1,
    ST_TTAR0,
    ST_TTAR1,
    ST_SKIP
  } lpcState_e;

  typedef enum logic [1:0] {
    DRV_SYNC,
    DRV_DLO,
    DRV_DHI,
    DRV_ONES
  } drvSel_e;

  typedef struct packed {
    logic                 addrShift;
    logic [DATA_NIBS-1:0] wdLoad;
    logic                 rdLoad;
    logic                 drvEn;
    drvSel_e              drvSel;
  } dpCtrl_t;

endpackage

// File: rtl/lpc_tgt_ctrl.sv
module lpc_tgt_ctrl
  import lpc_tgt_pkg::*;
#(
  parameter int ADDR_NIBS = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             frameN,
  input  logic [LAD_W-1:0] ladIn,
  output dpCtrl_t          dpCtrl,
  output logic             memWe,
  output logic             memRe
);

  localparam int CNT_W = (ADDR_NIBS > 1) ? $clog2(ADDR_NIBS) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ADDR_NIBS - 1);

  lpcState_e        state;
  lpcState_e        nextState;
  logic             isWrite;
  logic [CNT_W-1:0] nibCnt;
  logic             startSeen;

  assign startSeen = !frameN && (ladIn == NIB_START);

  // next-state: a low frame overrides every state
  always_comb begin
    nextState = state;
    if (!frameN) begin
      nextState = startSeen ? ST_TYPE : ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE:  nextState = ST_IDLE;
        ST_TYPE:  nextState = (ladIn[3:2] == MEM_KIND) ? ST_ADDR : ST_SKIP;
        ST_ADDR:  if (nibCnt == CNT_LAST) nextState = isWrite ? ST_WDAT0 : ST_HTAR0;
        ST_WDAT0: nextState = ST_WDAT1;
        ST_WDAT1: nextState = ST_HTAR0;
        ST_HTAR0: nextState = ST_HTAR1;
        ST_HTAR1: nextState = ST_SYNC;
        ST_SYNC:  nextState = isWrite ? ST_TTAR0 : ST_RDAT0;
        ST_RDAT0: nextState = ST_RDAT1;
        ST_RDAT1: nextState = ST_TTAR0;
        ST_TTAR0: nextState = ST_TTAR1;
        ST_TTAR1: nextState = ST_IDLE;
        ST_SKIP:  nextState = ST_SKIP;
        default:  nextState = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      isWrite <= 1'b0;
      nibCnt  <= '0;
      memWe   <= 1'b0;
      memRe   <= 1'b0;
    end else begin
      state <= nextState;
      if (state == ST_TYPE) isWrite <= ladIn[1];
      nibCnt <= (state == ST_ADDR && frameN) ? nibCnt + 1'b1 : '0;
      memWe  <= frameN && (state == ST_WDAT1);
      memRe  <= frameN && (state == ST_HTAR0) && !isWrite;
    end
  end

  // strobes toward the datapath
  always_comb begin
    dpCtrl           = '0;
    dpCtrl.drvSel    = DRV_SYNC;
    dpCtrl.addrShift = frameN && (state == ST_ADDR);
    dpCtrl.wdLoad[0] = frameN && (state == ST_WDAT0);
    dpCtrl.wdLoad[1] = frameN && (state == ST_WDAT1);
    dpCtrl.rdLoad    = (state == ST_SYNC) && !isWrite;
    unique case (state)
      ST_SYNC:  begin dpCtrl.drvEn = 1'b1; dpCtrl.drvSel = DRV_SYNC; end
      ST_RDAT0: begin dpCtrl.drvEn = 1'b1; dpCtrl.drvSel = DRV_DLO;  end
      ST_RDAT1: begin dpCtrl.drvEn = 1'b1; dpCtrl.drvSel = DRV_DHI;  end
      ST_TTAR0: begin dpCtrl.drvEn = 1'b1; dpCtrl.drvSel = DRV_ONES; end
      default:  begin dpCtrl.drvEn = 1'b0; dpCtrl.drvSel = DRV_SYNC; end
    endcase
  end

  AST_WE_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rstN)
    memWe |=> !memWe); // R4

  AST_RE_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rstN)
    memRe |=> !memRe); // R5

  AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(memWe && memRe)); // R2

  AST_ABORT_TO_START: assert property (@(posedge clk) disable iff (!rstN)
    !frameN |=> (state == ST_IDLE || state == ST_TYPE)); // R8

  AST_SKIP_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SKIP) |-> (!dpCtrl.drvEn && !memWe && !memRe)); // R9

  AST_DRIVE_OPENS_WITH_SYNC: assert property (@(posedge clk) disable iff (!rstN)
    (dpCtrl.drvEn && !$past(dpCtrl.drvEn)) |-> (dpCtrl.drvSel == DRV_SYNC)); // R6

endmodule

// File: rtl/lpc_tgt_dpath.sv
module lpc_tgt_dpath
  import lpc_tgt_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [LAD_W-1:0]  ladIn,
  input  dpCtrl_t           dpCtrl,
  input  logic [DATA_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic [LAD_W-1:0]  ladOut,
  output logic              ladOe
);

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdQ;
  logic [DATA_W-1:0] rdQ;

  // address enters most significant nibble first
  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ <= '0;
    end else if (dpCtrl.addrShift) begin
      addrQ <= {addrQ[ADDR_W-LAD_W-1:0], ladIn};
    end
  end

  // write data lanes, least significant nibble first
  for (genvar g = 0; g < DATA_NIBS; g++) begin : gWdLane
    always_ff @(posedge clk) begin
      if (!rstN) begin
        wdQ[g*LAD_W +: LAD_W] <= '0;
      end else if (dpCtrl.wdLoad[g]) begin
        wdQ[g*LAD_W +: LAD_W] <= ladIn;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdQ <= '0;
    end else if (dpCtrl.rdLoad) begin
      rdQ <= memRdata;
    end
  end

  always_comb begin
    ladOut = '0;
    if (dpCtrl.drvEn) begin
      unique case (dpCtrl.drvSel)
        DRV_SYNC: ladOut = NIB_READY;
        DRV_DLO:  ladOut = rdQ[LAD_W-1:0];
        DRV_DHI:  ladOut = rdQ[DATA_W-1:LAD_W];
        DRV_ONES: ladOut = NIB_ONES;
        default:  ladOut = NIB_ONES;
      endcase
    end
  end

  assign ladOe    = dpCtrl.drvEn;
  assign memAddr  = addrQ;
  assign memWdata = wdQ;

  AST_ADDR_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !dpCtrl.addrShift |=> $stable(memAddr)); // R3

  AST_WDATA_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (dpCtrl.wdLoad == '0) |=> $stable(memWdata)); // R4

  AST_RELEASE_AFTER_ONES: assert property (@(posedge clk) disable iff (!rstN)
    (dpCtrl.drvEn && dpCtrl.drvSel == DRV_ONES) |=> !ladOe); // R7

  AST_READY_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    (ladOe && dpCtrl.drvSel == DRV_SYNC) |-> (ladOut == NIB_READY)); // R6

endmodule

// File: rtl/lpc_mem_target.sv
module lpc_mem_target
  import lpc_tgt_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameN,
  input  logic [3:0]        ladIn,
  output logic [3:0]        ladOut,
  output logic              ladOe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memWdata,
  output logic              memWe,
  output logic              memRe,
  input  logic [7:0]        memRdata
);

  localparam int ADDR_NIBS = ADDR_W / LAD_W;

  dpCtrl_t dpCtrl;

  lpc_tgt_ctrl #(
    .ADDR_NIBS (ADDR_NIBS)
  ) i_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .frameN (frameN),
    .ladIn  (ladIn),
    .dpCtrl (dpCtrl),
    .memWe  (memWe),
    .memRe  (memRe)
  );

  lpc_tgt_dpath #(
    .ADDR_W (ADDR_W)
  ) i_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .ladIn    (ladIn),
    .dpCtrl   (dpCtrl),
    .memRdata (memRdata),
    .memAddr  (memAddr),
    .memWdata (memWdata),
    .ladOut   (ladOut),
    .ladOe    (ladOe)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rstN |=> (!ladOe && !memWe && !memRe)); // R10

endmodule

// File: tb/test_lpc_mem_target.sv
`timescale 1ns/1ps
module test_lpc_mem_target;

  logic        clk = 1'b0;
  logic        rstN;
  logic        frameN;
  logic [3:0]  ladIn;
  logic [3:0]  ladOut;
  logic        ladOe;
  logic [31:0] memAddr;
  logic [7:0]  memWdata;
  logic        memWe;
  logic        memRe;
  logic [7:0]  memRdata = 8'h00;

  int  nCmp = 0;
  int  nBad = 0;
  bit  finished = 1'b0;

  always #2.5 clk = ~clk;

  lpc_mem_target i_lpc_mem_target (
    .clk      (clk),
    .rstN     (rstN),
    .frameN   (frameN),
    .ladIn    (ladIn),
    .ladOut   (ladOut),
    .ladOe    (ladOe),
    .memAddr  (memAddr),
    .memWdata (memWdata),
    .memWe    (memWe),
    .memRe    (memRe),
    .memRdata (memRdata)
  );

  // memory model: answers one clock after the read strobe
  always @(posedge clk) begin
    if (memRe) memRdata <= memAddr[7:0] ^ 8'hA5;
  end

  // per-clock stimulus and expected outputs
  bit          qFr[$];
  logic [3:0]  qLad[$];
  bit          qOe[$];
  logic [3:0]  qOut[$];
  bit          qWe[$];
  bit          qRe[$];
  logic [31:0] qAddr[$];
  logic [7:0]  qWd[$];
  string       qTag[$];

  task automatic push(input bit fr, input logic [3:0] ld, input bit oe,
                      input logic [3:0] o, input bit we, input bit re,
                      input logic [31:0] a, input logic [7:0] d, input string t);
    qFr.push_back(fr);  qLad.push_back(ld);
    qOe.push_back(oe);  qOut.push_back(o);
    qWe.push_back(we);  qRe.push_back(re);
    qAddr.push_back(a); qWd.push_back(d);
    qTag.push_back(t);
  endtask

  task automatic addFill(input int n, input bit fr, input logic [3:0] ld, input string t);
    for (int i = 0; i < n; i++) push(fr, ld, 1'b0, 4'h0, 1'b0, 1'b0, 32'h0, 8'h0, t);
  endtask

  // one bus cycle; abortAt < 0 means no abort. An abort with nibble 0000
  // leaves that clock to the next cycle's start.
  task automatic addTxn(input bit isMem, input bit wr, input logic [3:0] typ,
                        input logic [31:0] a, input logic [7:0] d,
                        input int abortAt, input logic [3:0] abortLad, input string tag);
    logic [7:0] rd;
    rd = a[7:0] ^ 8'hA5;
    for (int k = 0; k <= 16; k++) begin
      bit fr; logic [3:0] ld; bit oe; logic [3:0] o; bit we; bit re; string t;
      if (abortAt >= 0 && k > abortAt) break;
      if (k == abortAt && abortLad == 4'h0) break;
      fr = 1'b1; ld = 4'hF; oe = 1'b0; o = 4'h0; we = 1'b0; re = 1'b0; t = tag;
      if (k == 0) begin fr = 1'b0; ld = 4'h0; end
      else if (k == 1) ld = typ;
      else if (k <= 9) ld = a[31-4*(k-2) -: 4];
      else if (isMem && wr && k == 10) ld = d[3:0];
      else if (isMem && wr && k == 11) ld = d[7:4];
      if (k == 10 && !(isMem && wr)) ld = 4'h0; // 0000 with frame high: no start (R1)
      if (k == abortAt) begin fr = 1'b0; ld = abortLad; end
      if (isMem && wr) begin
        if (k == 12) begin we = 1'b1; t = "R4"; end
        if (k == 14) begin oe = 1'b1; o = 4'h0; t = "R6"; end
        if (k == 15) begin oe = 1'b1; o = 4'hF; t = "R7"; end
        if (k == 16) t = "R7";
      end else if (isMem) begin
        if (k == 11) begin re = 1'b1; t = "R5"; end
        if (k == 12) begin oe = 1'b1; o = 4'h0; t = "R6"; end
        if (k == 13) begin oe = 1'b1; o = rd[3:0]; t = "R5"; end
        if (k == 14) begin oe = 1'b1; o = rd[7:4]; t = "R5"; end
        if (k == 15) begin oe = 1'b1; o = 4'hF; t = "R7"; end
        if (k == 16) t = "R7";
      end
      push(fr, ld, oe, o, we, re, a, d, t);
    end
  endtask

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nCmp++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic runQueue();
    while (qFr.size() > 0) begin
      bit fr; logic [3:0] ld; bit oe; logic [3:0] o; bit we; bit re;
      logic [31:0] a; logic [7:0] d; string t;
      fr = qFr.pop_front(); ld = qLad.pop_front();
      oe = qOe.pop_front(); o = qOut.pop_front();
      we = qWe.pop_front(); re = qRe.pop_front();
      a = qAddr.pop_front(); d = qWd.pop_front(); t = qTag.pop_front();
      @(negedge clk);
      chk(ladOe === oe, t, "ladOe", 32'(ladOe), 32'(oe));
      if (oe) chk(ladOut === o, t, "ladOut", 32'(ladOut), 32'(o));
      chk(memWe === we, we ? "R4" : t, "memWe", 32'(memWe), 32'(we));
      chk(memRe === re, re ? "R5" : t, "memRe", 32'(memRe), 32'(re));
      if (we || re) chk(memAddr === a, "R3", "memAddr", memAddr, a);
      if (we) chk(memWdata === d, "R4", "memWdata", 32'(memWdata), 32'(d));
      frameN = fr;
      ladIn  = ld;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nBad++;
      nCmp++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

  initial begin
    rstN   = 1'b0;
    frameN = 1'b1;
    ladIn  = 4'hF;
    repeat (3) @(negedge clk);
    chk(ladOe === 1'b0, "R10", "ladOe in reset", 32'(ladOe), 32'h0);
    chk(memWe === 1'b0, "R10", "memWe in reset", 32'(memWe), 32'h0);
    chk(memRe === 1'b0, "R10", "memRe in reset", 32'(memRe), 32'h0);
    rstN = 1'b1;

    addFill(2, 1'b1, 4'hF, "R1");
    addFill(2, 1'b0, 4'h5, "R1");   // low frame, not a start nibble
    addFill(3, 1'b1, 4'h0, "R1");   // start nibble with frame high
    addTxn(1'b1, 1'b1, 4'h6, 32'h12345678, 8'h9C, -1, 4'h0, "R4");
    addFill(2, 1'b1, 4'hF, "R1");
    addTxn(1'b1, 1'b0, 4'h4, 32'h000000F0, 8'h00, -1, 4'h0, "R5");
    addFill(2, 1'b1, 4'hF, "R1");
    addTxn(1'b1, 1'b1, 4'h7, 32'hFEDCBA98, 8'h3E, -1, 4'h0, "R2");
    addFill(2, 1'b1, 4'hF, "R2");
    addTxn(1'b1, 1'b0, 4'h5, 32'h89ABCDEF, 8'h00, -1, 4'h0, "R2");
    addFill(2, 1'b1, 4'hF, "R2");
    addTxn(1'b0, 1'b0, 4'h2, 32'h13579BDF, 8'h00, -1, 4'h0, "R9");
    addFill(3, 1'b1, 4'h0, "R9");
    addTxn(1'b0, 1'b0, 4'hD, 32'h2468ACE0, 8'h00, -1, 4'h0, "R9");
    addFill(2, 1'b1, 4'hF, "R9");
    addTxn(1'b1, 1'b1, 4'h6, 32'h0F1E2D3C, 8'h77, 11, 4'hF, "R8");
    addFill(4, 1'b1, 4'hF, "R8");
    addTxn(1'b1, 1'b0, 4'h4, 32'h4B5A6978, 8'h00, 10, 4'hF, "R8");
    addFill(4, 1'b1, 4'hF, "R8");
    addTxn(1'b1, 1'b0, 4'h4, 32'h0000003C, 8'h00, 13, 4'hF, "R8");
    addFill(4, 1'b1, 4'hF, "R8");
    addTxn(1'b1, 1'b1, 4'h6, 32'hDEADBEEF, 8'h11, 5, 4'h0, "R8");
    addTxn(1'b1, 1'b0, 4'h4, 32'hCAFE0011, 8'h00, -1, 4'h0, "R8");
    addTxn(1'b1, 1'b0, 4'h4, 32'h00000000, 8'h00, -1, 4'h0, "R5");
    addFill(3, 1'b1, 4'hF, "R7");
    runQueue();

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

endmodule